// File: doc/BRIEF.md
# Single-Precision Compare Unit with Subnormal Indicators

This block takes two IEEE-754 single-precision operands and reports how they relate. It returns a 32-bit result word. The low four bits hold a one-hot relation code: less-than, equal, greater-than or unordered. The next two bits mark each operand that is subnormal. The compare is quiet. Subnormal inputs are never flushed to zero, so each value is ordered by its true magnitude. Alongside the word, the block raises an invalid-operation strobe and a summary exception strobe for a downstream status unit.

The datapath is combinational. A registered stage presents the result one clock after the request. A two-state sequencer tracks whether the output stage holds a fresh result:

- `ST_IDLE`: the output holds nothing valid.
- `ST_HOLD`: the output carries the result of the request made on the previous cycle.

The sequencer has four named transitions:

- LAUNCH (`ST_IDLE` to `ST_HOLD`): taken when `in_valid` is high.
- STREAM (`ST_HOLD` to `ST_HOLD`): taken when back-to-back requests arrive.
- DRAIN (`ST_HOLD` to `ST_IDLE`): taken when `in_valid` drops.
- REST (`ST_IDLE` to `ST_IDLE`): taken while no request arrives.

Whenever `out_valid` is low, the result word and both strobes read zero.

Top module: `fcmp_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. It is low after reset. While it is low, `result` and both strobes are zero.
- R2: While `out_valid` is high, exactly one of `result[3:0]` is set. The encoding is bit 0 = less-than, bit 1 = equal, bit 2 = greater-than, bit 3 = unordered.
- R3: If either operand is a NaN (exponent all ones, fraction nonzero), the relation is unordered (bit 3).
- R4: Non-NaN operands are ordered by sign and magnitude. Any negative value is below any positive value. Among negatives, the larger magnitude is less. Infinities order as the extreme values. Identical encodings compare equal.
- R5: Positive zero and negative zero compare equal.
- R6: `result[4]` is set when operand A is subnormal (exponent zero, fraction nonzero). `result[5]` is set in the same way for operand B. A zero is never flagged as subnormal. Subnormals are ordered by their true value, not flushed to zero.
- R7: `exc_invalid` is raised only when at least one operand is a signalling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear). A quiet NaN alone raises nothing.
- R8: `exc_summary` is raised when any exception is raised, and is cleared for a compare that raises none.
- R9: `result[31:6]` is always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; operands are sampled in this cycle |
| op_a | input | 32 | First operand, single-precision encoding |
| op_b | input | 32 | Second operand, single-precision encoding |
| out_valid | output | 1 | Result and strobes are valid |
| result | output | 32 | Relation code in bits 3:0, subnormal marks in bits 5:4, zero above |
| exc_invalid | output | 1 | Invalid-operation strobe |
| exc_summary | output | 1 | Summary strobe: any exception raised |

## Verification
The bench crosses a table of edge encodings against itself, then adds a long run of random pairs biased toward equal exponents. The edge encodings are both zeros, the smallest and largest subnormals, normals, infinities, and quiet and signalling NaNs of both signs. The expected relation comes from mapping each operand to a signed integer key. A design that flushed subnormals would report two distinct subnormals as equal. A design that compared raw bit patterns would invert the order of negative numbers and would split the two zeros. A design that raised invalid for any NaN would fire the strobe on quiet NaNs. The bench also drops `in_valid` between bursts to confirm that the output clears on the DRAIN transition.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    // Bit positions of the one-hot relation code in the result word
    localparam int REL_LT    = 0;
    localparam int REL_EQ    = 1;
    localparam int REL_GT    = 2;
    localparam int REL_UNORD = 3;
    localparam int REL_W     = 4;
    localparam int SUB_A_BIT = 4;
    localparam int SUB_B_BIT = 5;

    // Operand class derived from the encoding
    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_sub;
        logic is_nan;
        logic is_snan;
    } opnd_cls_t;

    // Output-stage sequencer
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } fcmp_state_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0]   op,
    output opnd_cls_t               cls,
    output logic [EXP_W+FRAC_W-1:0] mag
);
    localparam int OP_W = EXP_W + FRAC_W + 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              exp_none;
    logic              frac_none;

    assign exp_f     = op[OP_W-2:FRAC_W];
    assign frac_f    = op[FRAC_W-1:0];
    assign exp_ones  = &exp_f;
    assign exp_none  = ~|exp_f;
    assign frac_none = ~|frac_f;

    always_comb begin
        cls.sign    = op[OP_W-1];
        cls.is_zero = exp_none & frac_none;
        cls.is_sub  = exp_none & ~frac_none;
        cls.is_nan  = exp_ones & ~frac_none;
        // quiet bit is the top fraction bit
        cls.is_snan = exp_ones & ~frac_none & ~frac_f[FRAC_W-1];
    end

    // Magnitude without the sign: monotonic in value for non-NaN encodings
    assign mag = op[OP_W-2:0];

    // Subnormal and zero are exclusive classes
    always_comb begin
        assert (!(cls.is_sub && cls.is_zero)) else $error("AST_SUB_NOT_ZERO"); // R6
    end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  opnd_cls_t          cls_a,
    input  opnd_cls_t          cls_b,
    input  logic [MAG_W-1:0]   mag_a,
    input  logic [MAG_W-1:0]   mag_b,
    output logic [REL_W-1:0]   rel
);
    logic mag_eq;
    logic mag_a_big;

    assign mag_eq    = (mag_a == mag_b);
    assign mag_a_big = (mag_a > mag_b);

    always_comb begin
        rel = '0;
        if (cls_a.is_nan || cls_b.is_nan) begin
            rel[REL_UNORD] = 1'b1;
        end else if (cls_a.is_zero && cls_b.is_zero) begin
            rel[REL_EQ] = 1'b1;
        end else if (cls_a.sign != cls_b.sign) begin
            if (cls_a.sign) rel[REL_LT] = 1'b1;
            else            rel[REL_GT] = 1'b1;
        end else if (mag_eq) begin
            rel[REL_EQ] = 1'b1;
        end else if (mag_a_big ^ cls_a.sign) begin
            rel[REL_GT] = 1'b1;
        end else begin
            rel[REL_LT] = 1'b1;
        end
    end

    always_comb begin
        assert ($countones(rel) == 1) else $error("AST_REL_ONE_HOT_COMB"); // R2
    end

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int RES_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [EXP_W+FRAC_W:0]     op_a,
    input  logic [EXP_W+FRAC_W:0]     op_b,
    output logic                      out_valid,
    output logic [RES_W-1:0]          result,
    output logic                      exc_invalid,
    output logic                      exc_summary
);
    localparam int OP_W  = EXP_W + FRAC_W + 1;
    localparam int MAG_W = OP_W - 1;
    localparam int N_OPS = 2;

    logic [OP_W-1:0]  ops  [N_OPS];
    opnd_cls_t        cls  [N_OPS];
    logic [MAG_W-1:0] mags [N_OPS];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fcmp_classify #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) i_classify (
            .op  (ops[g]),
            .cls (cls[g]),
            .mag (mags[g])
        );
    end

    logic [REL_W-1:0] rel;

    fcmp_order #(
        .MAG_W (MAG_W)
    ) i_order (
        .cls_a (cls[0]),
        .cls_b (cls[1]),
        .mag_a (mags[0]),
        .mag_b (mags[1]),
        .rel   (rel)
    );

    // Combinational result word and exception strobes
    logic [RES_W-1:0] res_d;
    logic             inv_d;
    logic             sum_d;

    always_comb begin
        res_d              = '0;
        res_d[REL_W-1:0]   = rel;
        res_d[SUB_A_BIT]   = cls[0].is_sub;
        res_d[SUB_B_BIT]   = cls[1].is_sub;
        inv_d              = cls[0].is_snan | cls[1].is_snan;
        sum_d              = inv_d;
    end

    // Sequencer: state register
    fcmp_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Sequencer: next state (LAUNCH, STREAM, DRAIN, REST)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output process: load on request, clear otherwise
    logic [RES_W-1:0] res_q;
    logic             inv_q;
    logic             sum_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            inv_q <= 1'b0;
            sum_q <= 1'b0;
        end else if (in_valid) begin
            res_q <= res_d;
            inv_q <= inv_d;
            sum_q <= sum_d;
        end else begin
            res_q <= '0;
            inv_q <= 1'b0;
            sum_q <= 1'b0;
        end
    end

    assign out_valid   = (state_q == ST_HOLD);
    assign result      = res_q;
    assign exc_invalid = inv_q;
    assign exc_summary = sum_q;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("AST_VALID_LATENCY"); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (result == '0 && !exc_invalid && !exc_summary)) else $error("AST_IDLE_QUIET"); // R1
    AST_REL_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(result[REL_W-1:0]) == 1)) else $error("AST_REL_ONE_HOT"); // R2
    AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cls[0].is_nan || cls[1].is_nan)) |=> result[REL_UNORD]) else $error("AST_NAN_UNORDERED"); // R3
    AST_INVALID_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
        exc_invalid |-> result[REL_UNORD]) else $error("AST_INVALID_UNORD"); // R7
    AST_SUMMARY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !result[REL_UNORD]) |-> !exc_summary) else $error("AST_SUMMARY_CLEAR"); // R8
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        result[RES_W-1:SUB_B_BIT+1] == '0) else $error("AST_UPPER_ZERO"); // R9

endmodule

// File: tb/test_fcmp_unit.sv
module test_fcmp_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N_PAT      = 24;
    localparam int N_RAND     = 3000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] op_a, op_b;
    logic        out_valid;
    logic [31:0] result;
    logic        exc_invalid, exc_summary;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmp_unit i_fcmp_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .op_a        (op_a),
        .op_b        (op_b),
        .out_valid   (out_valid),
        .result      (result),
        .exc_invalid (exc_invalid),
        .exc_summary (exc_summary)
    );

    function automatic logic [31:0] pat(input int i);
        case (i)
            0:  pat = 32'h0000_0000;  1:  pat = 32'h8000_0000;
            2:  pat = 32'h0000_0001;  3:  pat = 32'h8000_0001;
            4:  pat = 32'h007F_FFFF;  5:  pat = 32'h807F_FFFF;
            6:  pat = 32'h0000_0002;  7:  pat = 32'h0080_0000;
            8:  pat = 32'h3F80_0000;  9:  pat = 32'hBF80_0000;
            10: pat = 32'h3F80_0001;  11: pat = 32'hBF80_0001;
            12: pat = 32'h4000_0000;  13: pat = 32'hC000_0000;
            14: pat = 32'h7F7F_FFFF;  15: pat = 32'hFF7F_FFFF;
            16: pat = 32'h7F80_0000;  17: pat = 32'hFF80_0000;
            18: pat = 32'h7FC0_0000;  19: pat = 32'hFFC0_0001;
            20: pat = 32'h7F80_0001;  21: pat = 32'hFFBF_FFFF;
            22: pat = 32'h7FA0_0000;  default: pat = 32'h8080_0000;
        endcase
    endfunction

    function automatic bit is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic bit is_snan(input logic [31:0] x);
        return is_nan(x) && !x[22];
    endfunction

    function automatic bit is_subn(input logic [31:0] x);
        return (x[30:23] == 8'h00) && (x[22:0] != 0);
    endfunction

    // Signed integer key: value order for non-NaN encodings
    function automatic longint key(input logic [31:0] x);
        longint m = longint'(x[30:0]);
        return x[31] ? -m : m;
    endfunction

    function automatic logic [3:0] exp_rel(input logic [31:0] a, input logic [31:0] b);
        if (is_nan(a) || is_nan(b)) return 4'b1000;
        if (key(a) < key(b))        return 4'b0001;
        if (key(a) > key(b))        return 4'b0100;
        return 4'b0010;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, op_a, op_b, act, expv);
        end
    endtask

    // Drive one pair, check its result one cycle later
    task automatic run_pair(input logic [31:0] a, input logic [31:0] b);
        logic [3:0] er;
        string      rtag;
        bit         inv;
        @(negedge clk);
        in_valid = 1'b1;
        op_a = a;
        op_b = b;
        er  = exp_rel(a, b);
        inv = is_snan(a) || is_snan(b);
        if (is_nan(a) || is_nan(b))                          rtag = "R3";
        else if (a[30:0] == 0 && b[30:0] == 0)               rtag = "R5";
        else                                                 rtag = "R4";
        @(negedge clk);
        chk(out_valid == 1'b1, "R1 valid", 32'(out_valid), 32'd1);
        chk($countones(result[3:0]) == 1, "R2 onehot", result, 32'(er));
        chk(result[3:0] == er, rtag, 32'(result[3:0]), 32'(er));
        chk(result[5:4] == {is_subn(b), is_subn(a)}, "R6 subnormal", 32'(result[5:4]), 32'({is_subn(b), is_subn(a)}));
        chk(exc_invalid == inv, "R7 invalid", 32'(exc_invalid), 32'(inv));
        chk(exc_summary == inv, "R8 summary", 32'(exc_summary), 32'(inv));
        chk(result[31:6] == 0, "R9 upper", result, 32'(result[5:0]));
    endtask

    task automatic check_idle();
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 drain valid", 32'(out_valid), 32'd0);
        chk(result == 0 && !exc_invalid && !exc_summary, "R1 drain quiet", result, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0;
        op_a = '0;
        op_b = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset valid", 32'(out_valid), 32'd0);
        chk(result == 0, "R9 reset result", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && !exc_summary, "R1 post-reset", 32'(out_valid), 32'd0);

        // Exhaustive cross of edge encodings (R3 R4 R5 R6 R7)
        for (int i = 0; i < N_PAT; i++) begin
            for (int j = 0; j < N_PAT; j++) run_pair(pat(i), pat(j));
            if (i % 6 == 5) check_idle();
        end

        // Two distinct subnormals are ordered, not flushed (R6)
        run_pair(32'h0000_0003, 32'h0000_0005);
        chk(result[3:0] == 4'b0001, "R6 unflushed", 32'(result[3:0]), 32'd1);

        // Random pairs, half with shared exponent
        for (int k = 0; k < N_RAND; k++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = $urandom;
            if (k % 2 == 0) b[30:23] = a[30:23];
            if (k % 7 == 0) begin a[30:23] = 8'h00; b[30:23] = 8'h00; end
            if (k % 11 == 0) b = a ^ 32'h8000_0000;
            run_pair(a, b);
            if (k % 97 == 0) check_idle();
        end
        check_idle();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule